// File: doc/BRIEF.md
# Floating-Point Control Register Views

This block holds the 32-bit floating-point control and status register (FCSR) of a processor's floating-point unit, together with a read-only implementation identifier. Software reaches it through a small control-register port. A 5-bit register number, a read strobe, a write strobe and 32-bit write data go in. Registered read data and an error flag come out one cycle later. Besides the full register, three alias numbers each expose a scattered group of FCSR fields packed into a compact word. A write through an alias touches only the FCSR bits that the alias shows.

The eight floating-point condition-code bits are exported continuously for branch and conditional-move logic. A separate hardware update port lets the arithmetic pipeline report exceptions. It replaces the cause field and accumulates the sticky flag field.

Top module: `fcr_ctrl_views`

## Requirements
- R1: After synchronous reset, FCSR is zero, `fcc` is zero, and `cr_rvalid` and `cr_err` are low.
- R2: Register 0 reads the `IMPL_ID` parameter. A write to register 0 changes nothing and raises `cr_err`.
- R3: Register 31 reads the whole FCSR and writes all 32 bits of it.
- R4: Reading register 25 returns FCSR[31:25] in bits 7:1 and FCSR[23] in bit 0, with every other bit zero.
- R5: Writing register 25 loads FCSR[31:25] from data bits 7:1 and FCSR[23] from data bit 0, and leaves all other FCSR bits unchanged.
- R6: Reading register 26 returns FCSR AND 0x0003F07C, which is cause bits 17:12 and flag bits 6:2 in place.
- R7: Writing register 26 updates only FCSR[17:12] and FCSR[6:2], each from the same data bit positions.
- R8: Reading register 28 returns FCSR[11:7] and FCSR[1:0] in place and FCSR[24] in bit 2, with every other bit zero.
- R9: Writing register 28 updates FCSR[11:7] from data bits 11:7, FCSR[24] from data bit 2 and FCSR[1:0] from data bits 1:0, and nothing else.
- R10: An access to any register number other than 0, 25, 26, 28 or 31 raises `cr_err` in the next cycle. Such a read returns zero, and such a write leaves FCSR unchanged.
- R11: `fcc[0]` equals FCSR[23], and `fcc[k]` equals FCSR[24+k] for k from 1 to 7.
- R12: Timing of accesses:
  - Read data and `cr_rvalid` appear in the cycle after the read strobe.
  - A read in the same cycle as a write returns the value from before the write.
  - A read in the following cycle sees the new value.
- R13: When `hw_upd` is high, FCSR[17:12] takes `hw_cause` and FCSR[6:2] becomes its value ORed with `hw_flags`. If a software write happens in the same cycle, the hardware update is applied on top of the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cr_rd | input | 1 | Read strobe |
| cr_wr | input | 1 | Write strobe |
| cr_idx | input | 5 | Control register number |
| cr_wdata | input | 32 | Write data |
| hw_upd | input | 1 | Hardware exception update strobe |
| hw_cause | input | 6 | New cause field value |
| hw_flags | input | 5 | Flag bits to accumulate |
| cr_rdata | output | 32 | Registered read data |
| cr_rvalid | output | 1 | Read data valid, one cycle after `cr_rd` |
| cr_err | output | 1 | Invalid access indication, one cycle after the access |
| fcc | output | 8 | Condition-code bits |

## Verification
Two functions can fall in the same cycle. The first is a software write through any view, and the second is the hardware exception update, both of which target the cause and flag fields. The random phase raises `hw_upd` on about a third of its cycles, independently of the write strobe and the register number. It also includes a directed cycle with a register-26 write and a hardware update together. The outcome is judged by later reads of register 31 and register 26 against a bench model that applies the write first and then the update. A same-cycle read and write of one register is also provoked, to confirm that the read returns the old value.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int unsigned FCR_W    = 32;
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned NCC      = 8;
  // field placement inside FCSR
  localparam int unsigned CC0_POS  = 23;
  localparam int unsigned CCH_LO   = 25;
  localparam int unsigned CCH_W    = NCC - 1;
  localparam int unsigned FS_POS   = 24;
  localparam int unsigned CAUSE_LO = 12;
  localparam int unsigned CAUSE_W  = 6;
  localparam int unsigned FLAG_LO  = 2;
  localparam int unsigned FLAG_W   = 5;
  localparam int unsigned EN_LO    = 7;
  localparam int unsigned EN_W     = 5;
  localparam int unsigned RM_W     = 2;

  typedef enum logic [2:0] {
    V_IMPL = 3'd0,
    V_CC   = 3'd1,
    V_EXC  = 3'd2,
    V_MODE = 3'd3,
    V_FULL = 3'd4,
    V_BAD  = 3'd5
  } view_e;
endpackage

// File: rtl/fcr_view_decode.sv
module fcr_view_decode
  import fcr_pkg::*;
#(
  parameter int unsigned IDX_IMPL = 0,
  parameter int unsigned IDX_CC   = 25,
  parameter int unsigned IDX_EXC  = 26,
  parameter int unsigned IDX_MODE = 28,
  parameter int unsigned IDX_FULL = 31
) (
  input  logic [IDX_W-1:0] idx,
  output view_e            view
);
  always_comb begin
    if (idx == IDX_W'(IDX_IMPL))      view = V_IMPL;
    else if (idx == IDX_W'(IDX_CC))   view = V_CC;
    else if (idx == IDX_W'(IDX_EXC))  view = V_EXC;
    else if (idx == IDX_W'(IDX_MODE)) view = V_MODE;
    else if (idx == IDX_W'(IDX_FULL)) view = V_FULL;
    else                              view = V_BAD;
  end
endmodule

// File: rtl/fcr_read_pack.sv
module fcr_read_pack
  import fcr_pkg::*;
(
  input  view_e            view,
  input  logic [FCR_W-1:0] fcsr,
  input  logic [FCR_W-1:0] impl_id,
  output logic [FCR_W-1:0] data
);
  always_comb begin
    data = '0;
    unique case (view)
      V_IMPL: data = impl_id;
      V_FULL: data = fcsr;
      V_CC: begin
        data[CCH_W:1] = fcsr[CCH_LO +: CCH_W];
        data[0]       = fcsr[CC0_POS];
      end
      V_EXC: begin
        data[CAUSE_LO +: CAUSE_W] = fcsr[CAUSE_LO +: CAUSE_W];
        data[FLAG_LO  +: FLAG_W]  = fcsr[FLAG_LO  +: FLAG_W];
      end
      V_MODE: begin
        data[EN_LO +: EN_W] = fcsr[EN_LO +: EN_W];
        data[2]             = fcsr[FS_POS];
        data[RM_W-1:0]      = fcsr[RM_W-1:0];
      end
      default: data = '0;
    endcase
  end
endmodule

// File: rtl/fcr_write_merge.sv
module fcr_write_merge
  import fcr_pkg::*;
(
  input  view_e              view,
  input  logic               wr_en,
  input  logic [FCR_W-1:0]   cur,
  input  logic [FCR_W-1:0]   wdata,
  input  logic               hw_en,
  input  logic [CAUSE_W-1:0] hw_cause,
  input  logic [FLAG_W-1:0]  hw_flags,
  output logic [FCR_W-1:0]   nxt
);
  always_comb begin
    nxt = cur;
    if (wr_en) begin
      unique case (view)
        V_FULL: nxt = wdata;
        V_CC: begin
          nxt[CCH_LO +: CCH_W] = wdata[CCH_W:1];
          nxt[CC0_POS]         = wdata[0];
        end
        V_EXC: begin
          nxt[CAUSE_LO +: CAUSE_W] = wdata[CAUSE_LO +: CAUSE_W];
          nxt[FLAG_LO  +: FLAG_W]  = wdata[FLAG_LO  +: FLAG_W];
        end
        V_MODE: begin
          nxt[EN_LO +: EN_W] = wdata[EN_LO +: EN_W];
          nxt[FS_POS]        = wdata[2];
          nxt[RM_W-1:0]      = wdata[RM_W-1:0];
        end
        default: ;
      endcase
    end
    // hardware exception report lands on top of any software write
    if (hw_en) begin
      nxt[CAUSE_LO +: CAUSE_W] = hw_cause;
      nxt[FLAG_LO  +: FLAG_W]  = nxt[FLAG_LO +: FLAG_W] | hw_flags;
    end
  end
endmodule

// File: rtl/fcr_ctrl_views.sv
module fcr_ctrl_views
  import fcr_pkg::*;
#(
  parameter logic [31:0] IMPL_ID  = 32'h0001_3A20,
  parameter int unsigned IDX_IMPL = 0,
  parameter int unsigned IDX_CC   = 25,
  parameter int unsigned IDX_EXC  = 26,
  parameter int unsigned IDX_MODE = 28,
  parameter int unsigned IDX_FULL = 31
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cr_rd,
  input  logic                cr_wr,
  input  logic [IDX_W-1:0]    cr_idx,
  input  logic [FCR_W-1:0]    cr_wdata,
  input  logic                hw_upd,
  input  logic [CAUSE_W-1:0]  hw_cause,
  input  logic [FLAG_W-1:0]   hw_flags,
  output logic [FCR_W-1:0]    cr_rdata,
  output logic                cr_rvalid,
  output logic                cr_err,
  output logic [NCC-1:0]      fcc
);
  view_e            view;
  logic [FCR_W-1:0] fcsr_q;
  logic [FCR_W-1:0] fcsr_d;
  logic [FCR_W-1:0] rd_word;
  logic             bad_acc;

  fcr_view_decode #(
    .IDX_IMPL(IDX_IMPL), .IDX_CC(IDX_CC), .IDX_EXC(IDX_EXC),
    .IDX_MODE(IDX_MODE), .IDX_FULL(IDX_FULL)
  ) u_dec (
    .idx (cr_idx),
    .view(view)
  );

  fcr_read_pack u_rd (
    .view   (view),
    .fcsr   (fcsr_q),
    .impl_id(IMPL_ID),
    .data   (rd_word)
  );

  fcr_write_merge u_wr (
    .view    (view),
    .wr_en   (cr_wr),
    .cur     (fcsr_q),
    .wdata   (cr_wdata),
    .hw_en   (hw_upd),
    .hw_cause(hw_cause),
    .hw_flags(hw_flags),
    .nxt     (fcsr_d)
  );

  assign bad_acc = ((cr_rd || cr_wr) && view == V_BAD) || (cr_wr && view == V_IMPL);

  always_ff @(posedge clk) begin
    if (rst) begin
      fcsr_q    <= '0;
      cr_rdata  <= '0;
      cr_rvalid <= 1'b0;
      cr_err    <= 1'b0;
    end else begin
      fcsr_q    <= fcsr_d;
      cr_rvalid <= cr_rd;
      cr_err    <= bad_acc;
      if (cr_rd) cr_rdata <= rd_word;
    end
  end

  generate
    for (genvar k = 0; k < NCC; k++) begin : g_cc
      if (k == 0) begin : g_c0
        assign fcc[k] = fcsr_q[CC0_POS];
      end else begin : g_ch
        assign fcc[k] = fcsr_q[CCH_LO + k - 1];
      end
    end
  endgenerate

  // R3: a full-register write without hardware update is seen verbatim
  p_full_write_r3: assert property (@(posedge clk) disable iff (rst)
    (cr_wr && view == V_FULL && !hw_upd) |=> fcsr_q == $past(cr_wdata));

  // R11: condition codes follow a full-register write
  p_cc_follow_r11: assert property (@(posedge clk) disable iff (rst)
    (cr_wr && view == V_FULL && !hw_upd) |=>
      fcc == {$past(cr_wdata[31:25]), $past(cr_wdata[23])});

  // R7: an exception-view write keeps every bit outside its fields
  p_exc_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (cr_wr && view == V_EXC && !hw_upd) |=>
      (fcsr_q[31:18] == $past(fcsr_q[31:18])) &&
      (fcsr_q[11:7] == $past(fcsr_q[11:7])) &&
      (fcsr_q[1:0] == $past(fcsr_q[1:0])));

  // R10: bad register number flags an error and leaves state alone
  p_bad_err_r10: assert property (@(posedge clk) disable iff (rst)
    ((cr_rd || cr_wr) && view == V_BAD) |=> cr_err);

  p_bad_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (cr_wr && view == V_BAD && !hw_upd) |=> $stable(fcsr_q));

  // R12: read data valid one cycle after the strobe
  p_rvalid_r12: assert property (@(posedge clk) disable iff (rst)
    cr_rd |=> cr_rvalid);

  // R13: flags reported by hardware are present afterwards
  p_flag_sticky_r13: assert property (@(posedge clk) disable iff (rst)
    hw_upd |=> ((fcsr_q[6:2] & $past(hw_flags)) == $past(hw_flags)));
endmodule

// File: tb/fcr_ctrl_views_bench.sv
module fcr_ctrl_views_bench;
  localparam logic [31:0] IMPL = 32'h0001_3A20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cr_rd = 1'b0, cr_wr = 1'b0, hw_upd = 1'b0;
  logic [4:0]  cr_idx = '0;
  logic [31:0] cr_wdata = '0;
  logic [5:0]  hw_cause = '0;
  logic [4:0]  hw_flags = '0;
  logic [31:0] cr_rdata;
  logic        cr_rvalid, cr_err;
  logic [7:0]  fcc;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] model = '0;

  always #4 clk = ~clk;

  fcr_ctrl_views #(.IMPL_ID(IMPL)) u_fcr_ctrl_views (
    .clk, .rst, .cr_rd, .cr_wr, .cr_idx, .cr_wdata, .hw_upd, .hw_cause,
    .hw_flags, .cr_rdata, .cr_rvalid, .cr_err, .fcc);

  function automatic logic [31:0] m_read(logic [31:0] f, logic [4:0] i);
    case (i)
      5'd0:  return IMPL;
      5'd25: return (((f >> 25) & 32'h7F) << 1) | ((f >> 23) & 32'h1);
      5'd26: return f & 32'h0003F07C;
      5'd28: return (f & 32'h00000F83) | (((f >> 24) & 32'h1) << 2);
      5'd31: return f;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] m_write(logic [31:0] f, logic [4:0] i, logic [31:0] d);
    case (i)
      5'd25: return (f & ~32'hFE800000) | (((d >> 1) & 32'h7F) << 25) | ((d & 32'h1) << 23);
      5'd26: return (f & ~32'h0003F07C) | (d & 32'h0003F07C);
      5'd28: return (f & ~32'h01000F83) | (d & 32'h00000F83) | (((d >> 2) & 32'h1) << 24);
      5'd31: return d;
      default: return f;
    endcase
  endfunction

  function automatic bit is_valid(logic [4:0] i);
    return i == 0 || i == 25 || i == 26 || i == 28 || i == 31;
  endfunction

  function automatic string rd_tag(logic [4:0] i);
    case (i)
      5'd0: return "R2"; 5'd25: return "R4"; 5'd26: return "R6";
      5'd28: return "R8"; 5'd31: return "R3"; default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one access cycle; outputs checked 2 ns after the capturing edge
  task automatic op(bit rd, bit wr, logic [4:0] i, logic [31:0] d,
                    bit hw, logic [5:0] c, logic [4:0] fl);
    logic [31:0] exp_rd;
    bit exp_err;
    @(negedge clk);
    cr_rd = rd; cr_wr = wr; cr_idx = i; cr_wdata = d;
    hw_upd = hw; hw_cause = c; hw_flags = fl;
    exp_rd  = m_read(model, i);
    exp_err = (rd || wr) && (!is_valid(i) || (wr && i == 0));
    if (wr) model = m_write(model, i, d);
    if (hw) model = (model & ~32'h0003F07C) | (32'(c) << 12) |
                    (model & 32'h7C) | (32'(fl) << 2);
    @(posedge clk); #2;
    chk("R12 rvalid", 32'(cr_rvalid), 32'(rd));
    if (rd) chk(rd_tag(i), cr_rdata, exp_rd);
    chk((wr && i == 0) ? "R2 err" : "R10 err", 32'(cr_err), 32'(exp_err));
    chk("R11 fcc", 32'(fcc), 32'({model[31:25], model[23]}));
    cr_rd = 0; cr_wr = 0; hw_upd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1 reset state
    chk("R1 fcc", 32'(fcc), 32'h0);
    chk("R1 rvalid", 32'(cr_rvalid), 32'h0);
    chk("R1 err", 32'(cr_err), 32'h0);
    op(1, 0, 31, 0, 0, 0, 0);                     // R1 / R3 reads zero
    op(1, 0, 0, 0, 0, 0, 0);                      // R2 impl id
    op(0, 1, 0, 32'hFFFF_FFFF, 0, 0, 0);          // R2 write ignored, error
    op(1, 0, 31, 0, 0, 0, 0);
    op(0, 1, 25, 32'h0000_00FF, 0, 0, 0);         // R5 all codes set
    op(1, 0, 25, 0, 0, 0, 0);                     // R4 round trip 0xFF
    op(1, 0, 31, 0, 0, 0, 0);                     // expect FE800000
    op(0, 1, 28, 32'hFFFF_FFFF, 0, 0, 0);         // R9
    op(1, 0, 28, 0, 0, 0, 0);                     // R8
    op(1, 0, 31, 0, 0, 0, 0);
    op(1, 1, 26, 32'hFFFF_FFFF, 0, 0, 0);         // R12 read old on same-cycle write
    op(1, 0, 26, 0, 0, 0, 0);                     // R6 / R7 new value
    op(0, 1, 26, 32'h0, 1, 6'h2A, 5'h05);         // R13 collision with write
    op(1, 0, 31, 0, 0, 0, 0);
    op(1, 0, 7, 0, 0, 0, 0);                      // R10 bad read -> 0
    op(0, 1, 13, 32'hFFFF_FFFF, 0, 0, 0);         // R10 bad write ignored
    op(1, 0, 31, 0, 0, 0, 0);
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] i;
      case ($urandom % 6)
        0: i = 0; 1: i = 25; 2: i = 26; 3: i = 28; 4: i = 31;
        default: i = 5'($urandom);
      endcase
      op(($urandom % 2) == 0, ($urandom % 2) == 0, i, $urandom,
         ($urandom % 3) == 0, 6'($urandom), 5'($urandom));
    end
    op(1, 0, 31, 0, 0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule